// File: doc/BRIEF.md
# Instruction Fetch ECC Recovery Controller

This controller sits in the last stage of an instruction cache fetch pipeline. Each fetch arrives with flags that say whether the tag (meta) array or the data array failed its ECC check. It also carries the one-hot hit way, the set index, the line address and any exception already raised by translation or protection checks. A clean fetch gets its response in the next cycle. A fetch with an ECC failure is not reported as a fault. Instead, the controller invalidates the suspect line or lines in the valid array. After that it sends a miss request for the line to the next cache level and waits for the refill.

The extent of the invalidation depends on which array failed. A tag failure means the hit way itself cannot be trusted, so every way of the indexed set is cleared. A data failure clears only the hit way. The invalidation is always issued in the cycle before the miss request. A later fill therefore cannot meet a stale copy and produce a hit in two ways. An access fault is reported only when the refill comes back marked corrupt or denied. Such a refill still completes the request, so the pipeline never waits forever.

Recovery happens only while checking is enabled, and only for fetches that carry no earlier exception. A redirect flush abandons any recovery in progress and returns the controller to idle.

Top module: `ifetch_ecc_recover`

## Requirements
- R1: After reset, `resp_valid`, `inv_valid` and `miss_valid` are 0 and `fetch_ready` is 1.
- R2: A fetch accepted with `chk_en`=1, `fetch_exc`=0 and no ECC flag gives `resp_valid`=1 in the next cycle, with `resp_data`=`fetch_data` and `resp_exc`=0. No invalidation and no miss request are issued.
- R3: A fetch accepted with `chk_en`=1, `fetch_exc`=0 and `fetch_meta_err`=1 gives, in the next cycle, a one-cycle `inv_valid` pulse with `inv_set`=`fetch_set` and `inv_ways` all ones. This holds whatever `fetch_data_err` is.
- R4: A fetch accepted with `chk_en`=1, `fetch_exc`=0, `fetch_meta_err`=0 and `fetch_data_err`=1 gives, in the next cycle, an `inv_valid` pulse with `inv_set`=`fetch_set` and `inv_ways`=`fetch_way_oh`.
- R5: `miss_valid` rises in the cycle directly after the `inv_valid` pulse. The two are never high together.
- R6: While `miss_valid`=1 and `miss_ready`=0, `miss_valid` stays 1 and `miss_line` stays stable. `miss_line` equals the `fetch_line` of the recovering fetch. `miss_valid` falls after the cycle in which `miss_ready`=1.
- R7: A refill with `refill_corrupt`=0 gives `resp_valid`=1 in the next cycle, with `resp_data`=`refill_data` and `resp_exc`=0. An ECC error alone never yields a fault.
- R8: A refill with `refill_corrupt`=1 still completes the request. It gives `resp_valid`=1 in the next cycle with `resp_exc`=3 (access fault), and `fetch_ready` returns to 1.
- R9: With `chk_en`=0, the ECC flags are ignored and the fetch is answered exactly as in R2.
- R10: A fetch with `fetch_exc`≠0 starts no recovery. Its response comes in the next cycle with `resp_exc` equal to `fetch_exc` (1 page fault, 2 guest page fault, 3 access fault).
- R11: `redirect_flush`=1 at a clock edge returns the controller to idle. In the next cycle `resp_valid`, `inv_valid` and `miss_valid` are 0 and `fetch_ready` is 1. A refill arriving afterwards yields no response.
- R12: `fetch_ready` is 0 from the cycle after a recovering fetch is accepted until the cycle after its refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | ECC check and recovery enable |
| redirect_flush | input | 1 | Abandon current work and return to idle |
| fetch_valid | input | 1 | A fetch is presented |
| fetch_ready | output | 1 | Controller can accept a fetch |
| fetch_set | input | SET_W | Set index of the fetch |
| fetch_way_oh | input | WAYS | One-hot hit way |
| fetch_line | input | LINE_W | Line address of the fetch |
| fetch_data | input | DATA_W | Data read from the array |
| fetch_meta_err | input | 1 | Tag array ECC failure |
| fetch_data_err | input | 1 | Data array ECC failure |
| fetch_exc | input | 2 | Earlier exception code |
| inv_valid | output | 1 | Valid-array invalidate command |
| inv_set | output | SET_W | Set to invalidate |
| inv_ways | output | WAYS | Ways to invalidate |
| miss_valid | output | 1 | Refetch request valid |
| miss_ready | input | 1 | Miss unit accepts the request |
| miss_line | output | LINE_W | Line address to refetch |
| refill_valid | input | 1 | Refill response valid |
| refill_data | input | DATA_W | Refill data |
| refill_corrupt | input | 1 | Refill marked corrupt or denied |
| resp_valid | output | 1 | Final response valid |
| resp_data | output | DATA_W | Response data |
| resp_exc | output | 2 | Response exception code |

## Verification
Some rules are checked on every cycle against the port relations. The invalidation extent for tag and data failures and the strict order of invalidation before miss request are checked this way. So are the holding of a stalled miss request, the pass-through of earlier exceptions, the stall of new fetches during recovery and the quiet state after a redirect. The values carried by a response can only be shown by the bench's scenarios. These are the refill data or the fault code for a corrupt refill, the effect of disabling checks, and the absence of a response when a refill arrives after a redirect.

// File: rtl/ecc_rec_pkg.sv
package ecc_rec_pkg;
  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_PF   = 2'd1,
    EXC_GPF  = 2'd2,
    EXC_AF   = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INV   = 2'd1,
    ST_MISS  = 2'd2,
    ST_WAIT  = 2'd3
  } rec_state_e;
endpackage

// File: rtl/ecc_rec_classify.sv
module ecc_rec_classify #(
  parameter int WAYS = 4
) (
  input  logic            chk_en,
  input  logic [1:0]      exc_in,
  input  logic            meta_err,
  input  logic            data_err,
  input  logic [WAYS-1:0] way_oh,
  output logic            recover,
  output logic [WAYS-1:0] inv_mask
);
  logic no_prior_exc;

  assign no_prior_exc = (exc_in == ecc_rec_pkg::EXC_NONE);
  assign recover      = chk_en && no_prior_exc && (meta_err || data_err);

  // A tag failure makes the hit way untrustworthy: clear all ways.
  for (genvar w = 0; w < WAYS; w++) begin : g_mask
    assign inv_mask[w] = meta_err || way_oh[w];
  end
endmodule

// File: rtl/ecc_rec_fsm.sv
module ecc_rec_fsm #(
  parameter int WAYS   = 4,
  parameter int SET_W  = 6,
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_flush,
  input  logic              fetch_valid,
  input  logic              recover,
  input  logic [WAYS-1:0]   mask_in,
  input  logic [SET_W-1:0]  set_in,
  input  logic [LINE_W-1:0] line_in,
  input  logic              miss_ready,
  input  logic              refill_valid,
  output logic              fetch_ready,
  output logic              inv_valid,
  output logic [SET_W-1:0]  inv_set,
  output logic [WAYS-1:0]   inv_ways,
  output logic              miss_valid,
  output logic [LINE_W-1:0] miss_line,
  output logic              load_direct,
  output logic              load_refill
);
  import ecc_rec_pkg::*;

  rec_state_e        state_q, state_d;
  logic [SET_W-1:0]  set_q;
  logic [WAYS-1:0]   mask_q;
  logic [LINE_W-1:0] line_q;
  logic              accept;
  logic              capture_en;

  assign accept     = (state_q == ST_IDLE) && fetch_valid && !redirect_flush;
  assign capture_en = accept && recover;

  always_comb begin
    state_d     = state_q;
    load_direct = 1'b0;
    load_refill = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (recover) state_d     = ST_INV;
          else         load_direct = 1'b1;
        end
      end
      ST_INV:  state_d = ST_MISS;
      ST_MISS: if (miss_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (refill_valid) begin
          state_d     = ST_IDLE;
          load_refill = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (redirect_flush) begin
      state_d     = ST_IDLE;
      load_refill = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= '0;
      mask_q <= '0;
      line_q <= '0;
    end else if (capture_en) begin
      set_q  <= set_in;
      mask_q <= mask_in;
      line_q <= line_in;
    end
  end

  assign fetch_ready = (state_q == ST_IDLE);
  assign inv_valid   = (state_q == ST_INV);
  assign inv_set     = set_q;
  assign inv_ways    = mask_q;
  assign miss_valid  = (state_q == ST_MISS);
  assign miss_line   = line_q;
endmodule

// File: rtl/ecc_rec_resp.sv
module ecc_rec_resp #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_direct,
  input  logic              load_refill,
  input  logic [1:0]        fetch_exc,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic [DATA_W-1:0] refill_data,
  input  logic              refill_corrupt,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_exc
);
  import ecc_rec_pkg::*;

  logic              valid_d;
  logic              exc_en;
  logic              data_en;
  logic [1:0]        exc_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    valid_d = load_direct || load_refill;
    exc_en  = valid_d;
    exc_d   = load_refill ? (refill_corrupt ? EXC_AF : EXC_NONE) : fetch_exc;
    // Corrupt refill data is not captured.
    data_en = load_direct || (load_refill && !refill_corrupt);
    data_d  = load_refill ? refill_data : fetch_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      resp_exc <= EXC_NONE;
    else if (exc_en) resp_exc <= exc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_data <= '0;
    else if (data_en) resp_data <= data_d;
  end
endmodule

// File: rtl/ifetch_ecc_recover.sv
module ifetch_ecc_recover #(
  parameter int WAYS   = 4,
  parameter int SETS   = 64,
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              redirect_flush,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [SET_W-1:0]  fetch_set,
  input  logic [WAYS-1:0]   fetch_way_oh,
  input  logic [LINE_W-1:0] fetch_line,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic              fetch_meta_err,
  input  logic              fetch_data_err,
  input  logic [1:0]        fetch_exc,
  output logic              inv_valid,
  output logic [SET_W-1:0]  inv_set,
  output logic [WAYS-1:0]   inv_ways,
  output logic              miss_valid,
  input  logic              miss_ready,
  output logic [LINE_W-1:0] miss_line,
  input  logic              refill_valid,
  input  logic [DATA_W-1:0] refill_data,
  input  logic              refill_corrupt,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic [1:0]        resp_exc
);
  logic            recover;
  logic [WAYS-1:0] mask;
  logic            load_direct;
  logic            load_refill;

  ecc_rec_classify #(.WAYS(WAYS)) u_classify (
    .chk_en   (chk_en),
    .exc_in   (fetch_exc),
    .meta_err (fetch_meta_err),
    .data_err (fetch_data_err),
    .way_oh   (fetch_way_oh),
    .recover  (recover),
    .inv_mask (mask)
  );

  ecc_rec_fsm #(.WAYS(WAYS), .SET_W(SET_W), .LINE_W(LINE_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_flush (redirect_flush),
    .fetch_valid    (fetch_valid),
    .recover        (recover),
    .mask_in        (mask),
    .set_in         (fetch_set),
    .line_in        (fetch_line),
    .miss_ready     (miss_ready),
    .refill_valid   (refill_valid),
    .fetch_ready    (fetch_ready),
    .inv_valid      (inv_valid),
    .inv_set        (inv_set),
    .inv_ways       (inv_ways),
    .miss_valid     (miss_valid),
    .miss_line      (miss_line),
    .load_direct    (load_direct),
    .load_refill    (load_refill)
  );

  ecc_rec_resp #(.DATA_W(DATA_W)) u_resp (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_direct    (load_direct),
    .load_refill    (load_refill),
    .fetch_exc      (fetch_exc),
    .fetch_data     (fetch_data),
    .refill_data    (refill_data),
    .refill_corrupt (refill_corrupt),
    .resp_valid     (resp_valid),
    .resp_data      (resp_data),
    .resp_exc       (resp_exc)
  );
endmodule

// File: rtl/ifetch_ecc_recover_chk.sv
module ifetch_ecc_recover_chk #(
  parameter int WAYS  = 4,
  parameter int SET_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chk_en,
  input logic             redirect_flush,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [SET_W-1:0] fetch_set,
  input logic [WAYS-1:0]  fetch_way_oh,
  input logic             fetch_meta_err,
  input logic             fetch_data_err,
  input logic [1:0]       fetch_exc,
  input logic             inv_valid,
  input logic [SET_W-1:0] inv_set,
  input logic [WAYS-1:0]  inv_ways,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic [25:0]      miss_line,
  input logic             resp_valid,
  input logic [1:0]       resp_exc
);
  logic take;
  assign take = fetch_valid && fetch_ready && !redirect_flush;

  assert_meta_all_ways_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && chk_en && fetch_exc == 2'd0 && fetch_meta_err
    |=> inv_valid && (&inv_ways) && inv_set == $past(fetch_set));

  assert_data_hit_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && chk_en && fetch_exc == 2'd0 && !fetch_meta_err && fetch_data_err
    |=> inv_valid && inv_ways == $past(fetch_way_oh) && inv_set == $past(fetch_set));

  assert_inv_then_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && !redirect_flush |=> miss_valid);

  assert_inv_miss_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_valid && miss_valid));

  assert_miss_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !miss_ready && !redirect_flush |=> miss_valid && $stable(miss_line));

  assert_exc_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take && fetch_exc != 2'd0 |=> resp_valid && resp_exc == $past(fetch_exc) && !inv_valid);

  assert_redirect_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_flush |=> !resp_valid && !inv_valid && !miss_valid && fetch_ready);

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid || miss_valid) |-> !fetch_ready);
endmodule

bind ifetch_ecc_recover ifetch_ecc_recover_chk #(.WAYS(4), .SET_W(6)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .chk_en         (chk_en),
  .redirect_flush (redirect_flush),
  .fetch_valid    (fetch_valid),
  .fetch_ready    (fetch_ready),
  .fetch_set      (fetch_set),
  .fetch_way_oh   (fetch_way_oh),
  .fetch_meta_err (fetch_meta_err),
  .fetch_data_err (fetch_data_err),
  .fetch_exc      (fetch_exc),
  .inv_valid      (inv_valid),
  .inv_set        (inv_set),
  .inv_ways       (inv_ways),
  .miss_valid     (miss_valid),
  .miss_ready     (miss_ready),
  .miss_line      (miss_line),
  .resp_valid     (resp_valid),
  .resp_exc       (resp_exc)
);

// File: tb/ifetch_ecc_recover_tb.sv
`timescale 1ns/1ps
module ifetch_ecc_recover_tb;
  localparam int WAYS = 4, SETS = 64, LINE_W = 26, DATA_W = 64;
  localparam int SET_W = $clog2(SETS);

  logic clk = 1'b0;
  logic rst_n;
  logic chk_en, redirect_flush, fetch_valid, fetch_ready;
  logic [SET_W-1:0] fetch_set, inv_set;
  logic [WAYS-1:0] fetch_way_oh, inv_ways;
  logic [LINE_W-1:0] fetch_line, miss_line;
  logic [DATA_W-1:0] fetch_data, refill_data, resp_data;
  logic fetch_meta_err, fetch_data_err, inv_valid, miss_valid, miss_ready;
  logic refill_valid, refill_corrupt, resp_valid;
  logic [1:0] fetch_exc, resp_exc;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ifetch_ecc_recover #(.WAYS(WAYS), .SETS(SETS), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .redirect_flush(redirect_flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_set(fetch_set),
    .fetch_way_oh(fetch_way_oh), .fetch_line(fetch_line), .fetch_data(fetch_data),
    .fetch_meta_err(fetch_meta_err), .fetch_data_err(fetch_data_err), .fetch_exc(fetch_exc),
    .inv_valid(inv_valid), .inv_set(inv_set), .inv_ways(inv_ways),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .refill_valid(refill_valid), .refill_data(refill_data), .refill_corrupt(refill_corrupt),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_exc(resp_exc)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    fetch_valid = 0; fetch_meta_err = 0; fetch_data_err = 0; fetch_exc = 0;
    miss_ready = 0; refill_valid = 0; refill_corrupt = 0; redirect_flush = 0;
  endtask

  task automatic put_fetch(input logic [SET_W-1:0] s, input logic [WAYS-1:0] w,
                           input logic [LINE_W-1:0] l, input logic [63:0] d,
                           input logic me, input logic de, input logic [1:0] e);
    fetch_valid = 1; fetch_set = s; fetch_way_oh = w; fetch_line = l; fetch_data = d;
    fetch_meta_err = me; fetch_data_err = de; fetch_exc = e;
  endtask

  task automatic t_reset();
    chk("R1", "resp_valid", resp_valid, 0);
    chk("R1", "inv_valid", inv_valid, 0);
    chk("R1", "miss_valid", miss_valid, 0);
    chk("R1", "fetch_ready", fetch_ready, 1);
  endtask

  task automatic t_clean(input string req, input logic en, input logic me, input logic de);
    chk_en = en;
    put_fetch(6'd5, 4'b0010, 26'h12345, 64'hA5A5_0000_1111_2222, me, de, 2'd0);
    tick();
    fetch_valid = 0;
    chk(req, "resp_valid", resp_valid, 1);
    chk(req, "resp_data", resp_data, 64'hA5A5_0000_1111_2222);
    chk(req, "resp_exc", resp_exc, 0);
    chk(req, "inv_valid", inv_valid, 0);
    tick();
    chk(req, "resp_valid end", resp_valid, 0);
    chk(req, "miss_valid", miss_valid, 0);
    chk(req, "fetch_ready", fetch_ready, 1);
    chk_en = 1;
  endtask

  task automatic t_recover(input string req, input logic me, input logic de,
                           input logic [WAYS-1:0] way, input logic [WAYS-1:0] exp_mask,
                           input logic corrupt);
    put_fetch(6'd33, way, 26'h2ABCDE, 64'h1, me, de, 2'd0);
    tick();
    fetch_valid = 0;
    chk(req, "inv_valid", inv_valid, 1);
    chk(req, "inv_set", inv_set, 6'd33);
    chk(req, "inv_ways", inv_ways, exp_mask);
    chk("R5", "miss_valid with inv", miss_valid, 0);
    chk("R12", "fetch_ready stalled", fetch_ready, 0);
    chk(req, "no resp yet", resp_valid, 0);
    tick();
    chk("R5", "inv_valid off", inv_valid, 0);
    chk("R5", "miss_valid after inv", miss_valid, 1);
    chk("R6", "miss_line", miss_line, 26'h2ABCDE);
    tick();
    chk("R6", "miss held", miss_valid, 1);
    chk("R6", "miss_line held", miss_line, 26'h2ABCDE);
    miss_ready = 1;
    tick();
    miss_ready = 0;
    chk("R6", "miss dropped", miss_valid, 0);
    chk("R12", "still stalled", fetch_ready, 0);
    tick();
    chk("R12", "waiting refill", fetch_ready, 0);
    refill_valid = 1; refill_data = 64'hFEED_BEEF_0000_0042; refill_corrupt = corrupt;
    tick();
    refill_valid = 0; refill_corrupt = 0;
    if (corrupt) begin
      chk("R8", "resp_valid", resp_valid, 1);
      chk("R8", "resp_exc fault", resp_exc, 3);
      chk("R8", "fetch_ready back", fetch_ready, 1);
    end else begin
      chk("R7", "resp_valid", resp_valid, 1);
      chk("R7", "resp_exc none", resp_exc, 0);
      chk("R7", "resp_data", resp_data, 64'hFEED_BEEF_0000_0042);
      chk("R12", "fetch_ready back", fetch_ready, 1);
    end
    tick();
    chk(req, "resp one cycle", resp_valid, 0);
  endtask

  task automatic t_prior_exc(input logic [1:0] e);
    put_fetch(6'd9, 4'b0100, 26'h77, 64'h99, 1'b1, 1'b1, e);
    tick();
    fetch_valid = 0;
    chk("R10", "resp_valid", resp_valid, 1);
    chk("R10", "resp_exc", resp_exc, e);
    chk("R10", "no inv", inv_valid, 0);
    tick();
    chk("R10", "no miss", miss_valid, 0);
    chk("R10", "ready", fetch_ready, 1);
  endtask

  task automatic t_redirect();
    put_fetch(6'd2, 4'b1000, 26'h55, 64'h0, 1'b0, 1'b1, 2'd0);
    tick();
    fetch_valid = 0;
    chk("R4", "inv_ways hit way", inv_ways, 4'b1000);
    tick();
    chk("R11", "in miss state", miss_valid, 1);
    redirect_flush = 1;
    tick();
    redirect_flush = 0;
    chk("R11", "miss cleared", miss_valid, 0);
    chk("R11", "ready again", fetch_ready, 1);
    chk("R11", "no resp", resp_valid, 0);
    refill_valid = 1; refill_data = 64'h3;
    tick();
    refill_valid = 0;
    chk("R11", "late refill ignored", resp_valid, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    chk_en = 1; fetch_set = 0; fetch_way_oh = 0; fetch_line = 0; fetch_data = 0;
    refill_data = 0;
    rst_n = 0;
    #11;
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_clean("R2", 1'b1, 1'b0, 1'b0);
    t_clean("R9", 1'b0, 1'b1, 1'b1);
    t_recover("R3", 1'b1, 1'b0, 4'b0001, 4'b1111, 1'b0);
    t_recover("R3", 1'b1, 1'b1, 4'b0100, 4'b1111, 1'b0);
    t_recover("R4", 1'b0, 1'b1, 4'b0100, 4'b0100, 1'b0);
    t_recover("R8", 1'b0, 1'b1, 4'b0010, 4'b0010, 1'b1);
    t_prior_exc(2'd1);
    t_prior_exc(2'd2);
    t_prior_exc(2'd3);
    t_redirect();
    t_clean("R2", 1'b1, 1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule